// File: doc/BRIEF.md
# Card Management Port Block

This block is a small register file on the peripheral side of a card. The host reaches it through three I/O addresses in a row: a control port, a data-low port and a data-high port. The host gains access by writing an unlock byte to the control port. The next control-port write is then taken as a command number, and that number picks what the data ports return. One command returns a fixed protocol version. Another streams an identification string one character per data-high read.

The block sits behind an address decoder on a synchronous internal bus. A cycle with `io_rd` high counts as exactly one read access, and a cycle with `io_wr` high counts as exactly one write access. Read data is registered. Any cycle without a decoded read leaves the bus at 0xFF, the value of an undriven bus. The base address is a parameter, so the block can also answer at a high alias such as 0x81D0 when a bridge forwards only a high I/O window.

Top module: `mgmt_port_top`

## Requirements
- R1: The control port sits at BASE, the data-low port at BASE+1 and the data-high port at BASE+2, with a 16-bit address and a default BASE of 0x01D0.
- R2: `io_rdata` carries the read result in the cycle after the clock edge that sampled `io_rd`. After any edge where no read was sampled, it shows 0xFF.
- R3: A control-port write of 0xCC while unarmed arms the block. The next control-port write is taken as the command and disarms the block. Any other control-port write while unarmed is ignored and leaves the command unchanged.
- R4: With command 0x01 selected, every data-high read returns 0x03.
- R5: With command 0x02 selected, successive data-high reads return the bytes 0x70 0x69 0x63 0x6F 0x67 0x75 0x73 0x2D in that order, and the string position never exceeds 8.
- R6: Once all 8 string bytes have been read, data-high reads return 0x00 until a new command is taken. Taking command 0x02 again restarts the string at its first byte.
- R7: Data-high reads under any command other than 0x01 or 0x02 return 0xFF. This includes the state after reset, when no command has been taken. Reads of the control port and of any address outside the three ports also return 0xFF.
- R8: A data-low read returns the current command number and does not move the string position.
- R9: Writes to the data-low or data-high port do not change the command, the armed state or the string position.
- R10: After reset the block is unarmed, the command is 0x00 and `io_rdata` is 0xFF.
- R11: An instance built with BASE = 0x81D0 answers at 0x81D0 to 0x81D2. Traffic at those addresses does not disturb an instance at 0x01D0, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one access per high cycle |
| io_rd | input | 1 | Read strobe, one access per high cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, 0xFF when idle |

## Verification
The hardest state to reach is the end of the string, where the pointer has to stay put while other traffic arrives. To get there, the stimulus interleaves data-low reads and data-port writes among the eight string reads. It then reads past the end and checks that the pointer neither moved early nor wrapped. The disarm path needs a similar setup: a command byte is followed by a second control write that must be ignored. The alias case runs two instances on one shared bus, so every access aimed at one instance is also a miss seen by the other.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

  localparam logic [7:0] UNLOCK_KEY = 8'hCC;
  localparam logic [7:0] CMD_PROTO  = 8'h01;
  localparam logic [7:0] CMD_IDSTR  = 8'h02;
  localparam logic [7:0] PROTO_VER  = 8'h03;
  localparam logic [7:0] BUS_IDLE   = 8'hFF;
  localparam logic [7:0] STR_DONE   = 8'h00;
  localparam int         ID_LEN     = 8;
  localparam int         IDX_W      = $clog2(ID_LEN + 1);

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_CTL  = 2'd1,
    PORT_DLO  = 2'd2,
    PORT_DHI  = 2'd3
  } port_sel_e;

  // Identification character at a given position; zero past the end.
  function automatic logic [7:0] id_char(input logic [IDX_W-1:0] idx);
    logic [7:0] c;
    case (idx)
      IDX_W'(0): c = 8'h70;
      IDX_W'(1): c = 8'h69;
      IDX_W'(2): c = 8'h63;
      IDX_W'(3): c = 8'h6F;
      IDX_W'(4): c = 8'h67;
      IDX_W'(5): c = 8'h75;
      IDX_W'(6): c = 8'h73;
      IDX_W'(7): c = 8'h2D;
      default:   c = STR_DONE;
    endcase
    return c;
  endfunction

  // Value presented on a data-high read for a command and string position.
  function automatic logic [7:0] hi_value_of(input logic [7:0] cmd,
                                             input logic [IDX_W-1:0] idx);
    logic [7:0] v;
    if (cmd == CMD_PROTO)      v = PROTO_VER;
    else if (cmd == CMD_IDSTR) v = id_char(idx);
    else                       v = BUS_IDLE;
    return v;
  endfunction

endpackage

// File: rtl/mgmt_decode.sv
module mgmt_decode
  import mgmt_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h01D0
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output port_sel_e         sel,
  output logic              ctl_wr,
  output logic              rd_hi
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = io_addr - BASE;
    if (offset == ADDR_W'(0))      sel = PORT_CTL;
    else if (offset == ADDR_W'(1)) sel = PORT_DLO;
    else if (offset == ADDR_W'(2)) sel = PORT_DHI;
    else                           sel = PORT_NONE;
  end

  assign ctl_wr = io_wr && (sel == PORT_CTL);
  assign rd_hi  = io_rd && (sel == PORT_DHI);

endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
  import mgmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] wdata,
  output logic       armed,
  output logic [7:0] cmd,
  output logic       cmd_load
);
  assign cmd_load = armed && ctl_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cmd   <= 8'h00;
    end else if (cmd_load) begin
      armed <= 1'b0;
      cmd   <= wdata;
    end else if (ctl_wr && (wdata == UNLOCK_KEY)) begin
      armed <= 1'b1;
    end
  end

endmodule

// File: rtl/mgmt_stream.sv
module mgmt_stream
  import mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_load,
  input  logic [7:0]       cmd,
  input  logic             rd_hi,
  output logic [IDX_W-1:0] str_idx,
  output logic [7:0]       hi_value
);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(ID_LEN);

  logic step;
  assign step = rd_hi && (cmd == CMD_IDSTR) && (str_idx != END_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)        str_idx <= '0;
    else if (cmd_load) str_idx <= '0;
    else if (step)     str_idx <= str_idx + IDX_W'(1);
  end

  assign hi_value = hi_value_of(cmd, str_idx);

endmodule

// File: rtl/mgmt_port_top.sv
module mgmt_port_top
  import mgmt_pkg::*;
#(
  parameter int                ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE   = 16'h01D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata
);
  port_sel_e        sel;
  logic             ctl_wr;
  logic             rd_hi;
  logic             armed;
  logic [7:0]       cmd;
  logic             cmd_load;
  logic [IDX_W-1:0] str_idx;
  logic [7:0]       hi_value;
  logic [7:0]       rd_next;

  mgmt_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .sel     (sel),
    .ctl_wr  (ctl_wr),
    .rd_hi   (rd_hi)
  );

  mgmt_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .wdata    (io_wdata),
    .armed    (armed),
    .cmd      (cmd),
    .cmd_load (cmd_load)
  );

  mgmt_stream u_str (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_load (cmd_load),
    .cmd      (cmd),
    .rd_hi    (rd_hi),
    .str_idx  (str_idx),
    .hi_value (hi_value)
  );

  always_comb begin
    rd_next = BUS_IDLE;
    if (io_rd) begin
      case (sel)
        PORT_DLO: rd_next = cmd;
        PORT_DHI: rd_next = hi_value;
        default:  rd_next = BUS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) io_rdata <= BUS_IDLE;
    else        io_rdata <= rd_next;
  end

endmodule

// File: rtl/mgmt_port_chk.sv
module mgmt_port_chk
  import mgmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             io_rd,
  input logic             io_wr,
  input logic [7:0]       io_wdata,
  input logic [7:0]       io_rdata,
  input port_sel_e        sel,
  input logic             ctl_wr,
  input logic             armed,
  input logic [7:0]       cmd,
  input logic [IDX_W-1:0] str_idx
);
  localparam logic [IDX_W-1:0] END_IDX = IDX_W'(ID_LEN);

  AST_IDLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> io_rdata == BUS_IDLE); // R2
  AST_MISS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (sel == PORT_NONE || sel == PORT_CTL)) |=> io_rdata == BUS_IDLE); // R7
  AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && ctl_wr && io_wdata == UNLOCK_KEY) |=> armed); // R3
  AST_CMD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ctl_wr) |=> (!armed && cmd == $past(io_wdata))); // R3
  AST_UNARMED_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && ctl_wr && io_wdata != UNLOCK_KEY) |=> (!armed && $stable(cmd))); // R3
  AST_PROTO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && sel == PORT_DHI && cmd == CMD_PROTO) |=> io_rdata == PROTO_VER); // R4
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    str_idx <= END_IDX); // R5
  AST_STR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && sel == PORT_DHI && cmd == CMD_IDSTR && str_idx == END_IDX && !ctl_wr)
      |=> (io_rdata == STR_DONE && str_idx == END_IDX)); // R6
  AST_DLO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && sel == PORT_DLO && !ctl_wr) |=> (io_rdata == cmd && $stable(str_idx))); // R8
  AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_rd && (sel == PORT_DLO || sel == PORT_DHI))
      |=> ($stable(cmd) && $stable(str_idx) && $stable(armed))); // R9

endmodule

bind mgmt_port_top mgmt_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_rd    (io_rd),
  .io_wr    (io_wr),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .sel      (sel),
  .ctl_wr   (ctl_wr),
  .armed    (armed),
  .cmd      (cmd),
  .str_idx  (str_idx)
);

// File: tb/mgmt_port_top_test.sv
module mgmt_port_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  rdata_lo;
  logic [7:0]  rdata_hi;

  always #5 clk = ~clk;

  mgmt_port_top #(.ADDR_W(16), .BASE(16'h01D0)) uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata_lo));

  mgmt_port_top #(.ADDR_W(16), .BASE(16'h81D0)) uut_hi (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rdata_hi));

  int compared = 0;
  int mismatched = 0;
  bit     q_which[$];
  logic [7:0] q_exp[$];
  string  q_tag[$];
  logic   rd_q = 1'b0;

  always @(posedge clk) rd_q <= io_rd;

  task automatic compare(input string tag, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Monitor: one expected item per sampled read strobe.
  always @(negedge clk) begin
    if (rst_n && rd_q) begin
      if (q_exp.size() == 0) begin
        compare("scoreboard-empty", 8'h00, 8'h01);
      end else begin
        automatic bit w = q_which.pop_front();
        automatic logic [7:0] e = q_exp.pop_front();
        automatic string t = q_tag.pop_front();
        compare(t, w ? rdata_hi : rdata_lo, e);
      end
    end
  end

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a, input bit which,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    q_which.push_back(which); q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    compare(tag, rdata_lo, 8'hFF);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  logic [7:0] id_bytes [8] = '{8'h70, 8'h69, 8'h63, 8'h6F, 8'h67, 8'h75, 8'h73, 8'h2D};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R10 reset rdata", rdata_lo, 8'hFF);
    compare("R10 reset rdata alias", rdata_hi, 8'hFF);
    rst_n = 1'b1;

    do_read(16'h01D1, 0, 8'h00, "R10 R8 command after reset");
    do_read(16'h01D2, 0, 8'hFF, "R7 no command yet");

    // R3: unarmed writes other than the key are ignored
    do_write(16'h01D0, 8'h55);
    do_write(16'h01D0, 8'h01);
    do_read(16'h01D1, 0, 8'h00, "R3 unarmed write ignored");

    // R4: protocol version
    do_write(16'h01D0, 8'hCC);
    do_write(16'h01D0, 8'h01);
    do_read(16'h01D1, 0, 8'h01, "R8 command readback");
    do_read(16'h01D2, 0, 8'h03, "R4 version read 1");
    do_read(16'h01D2, 0, 8'h03, "R4 version read 2");
    check_idle("R2 idle after read");

    // R3: command byte disarms; a lone 0x02 is ignored
    do_write(16'h01D0, 8'h02);
    do_read(16'h01D2, 0, 8'h03, "R3 disarmed after command");

    // R5/R8/R9: string with interleaved traffic
    do_write(16'h01D0, 8'hCC);
    do_write(16'h01D0, 8'h02);
    for (int i = 0; i < 8; i++) begin
      do_read(16'h01D2, 0, id_bytes[i], $sformatf("R5 string byte %0d", i));
      if (i == 2) do_read(16'h01D1, 0, 8'h02, "R8 data-low no advance");
      if (i == 4) begin
        do_write(16'h01D2, 8'hCC);
        do_write(16'h01D1, 8'h01);
      end
    end
    for (int i = 0; i < 3; i++)
      do_read(16'h01D2, 0, 8'h00, "R6 past end");
    do_read(16'h01D1, 0, 8'h02, "R9 data writes ignored");

    // R6: restart
    do_write(16'h01D0, 8'hCC);
    do_write(16'h01D0, 8'h02);
    do_read(16'h01D2, 0, 8'h70, "R6 restart first byte");
    do_read(16'h01D2, 0, 8'h69, "R6 restart second byte");

    // R7: unknown command and unmatched addresses
    do_write(16'h01D0, 8'hCC);
    do_write(16'h01D0, 8'h7E);
    do_read(16'h01D2, 0, 8'hFF, "R7 unknown command");
    do_read(16'h01D1, 0, 8'h7E, "R8 unknown command readback");
    do_read(16'h01D0, 0, 8'hFF, "R7 control port read");
    do_read(16'h01D3, 0, 8'hFF, "R7 address above range");
    do_read(16'h01CF, 0, 8'hFF, "R1 address below range");
    check_idle("R2 idle after miss");

    // R11: alias instance
    do_write(16'h81D0, 8'hCC);
    do_write(16'h81D0, 8'h01);
    do_read(16'h81D2, 1, 8'h03, "R11 alias version");
    do_read(16'h81D1, 1, 8'h01, "R11 alias command");
    do_read(16'h01D2, 1, 8'hFF, "R11 low address misses alias");
    do_read(16'h01D1, 0, 8'h7E, "R11 base instance undisturbed");
    do_read(16'h81D2, 0, 8'hFF, "R11 alias address misses base");

    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) compare("scoreboard-leftover", 8'(q_exp.size()), 8'h00);
    finish_run();
  end

endmodule